// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block holds the two programmable threshold values that a large synchronous FIFO uses to raise its almost-empty and almost-full flags. The surrounding FIFO gives it the same write enable, read enable and data bus that it uses for memory traffic, plus a load strobe and a serial shift strobe. While the load strobe is high, write and read enables access the offset registers and not the memory. While it is low, they pass through as ordinary memory requests. The block outputs both offsets continuously, for the flag comparators.

There are two ways to program the offsets, and the choice is taken from a mode input while master reset is held. In parallel mode each offset is split into slot-wide pieces (by default three 8-bit slots for an 18-bit offset). One pointer on the write clock steps through the six slots: almost-empty offset from low to high, then almost-full offset from low to high. A second pointer on the read clock steps through the same order for read-back. In serial mode one bit enters a combined shift chain of twice the offset width on each write clock edge. The first bit is the almost-empty offset's LSB and the last bit is the almost-full offset's MSB. Read-back through the slot sequence works in either mode. The programming sequence is the same whether the FIFO runs in standard or first-word-fall-through mode, so the block has no input for that mode.

Top module: `ofl_offset_loader`

## Requirements
- R1: While `mrst` is high, `serial_mode` copies `mode_sel` on each `wclk` edge (1 = serial, 0 = parallel). After `mrst` falls, `serial_mode` keeps that value whatever `mode_sel` does.
- R2: After master reset, `empty_ofs` and `full_ofs` both equal 7 and `ofs_dout_vld` is 0. The write slot pointer, the read slot pointer and the serial bit count all start at slot 0 / bit 0.
- R3: In parallel mode, with `load`=1 and `wr_en`=1, each `wclk` edge writes `din` into the next slot and wraps after slot 5. Slots 0, 1 and 2 hold almost-empty bits 7:0, 15:8 and 17:16 (from `din[1:0]`, the other `din` bits dropped). Slots 3, 4 and 5 hold the same fields of almost-full.
- R4: `empty_ofs` changes only on the edge that writes slot 2 or completes a serial load. `full_ofs` changes only on the edge that writes slot 5 or completes a serial load. Writes to the lower slots are staged and stay invisible until then.
- R5: With `load`=1 and `rd_en`=1, each `rclk` edge sets `ofs_dout_vld` to 1 for one cycle and puts the next slot's value, zero-extended, on `ofs_dout`. It uses the same order as R3 and wraps after slot 5. The read pointer is independent of the write pointer.
- R6: Parallel read-back as in R5 works when serial mode is selected.
- R7: In serial mode, `load`=1 with `wr_en`=1 leaves both offsets unchanged and raises no memory write.
- R8: In serial mode, with `load`=0, `wr_en`=0, `rd_en`=0 and `shift_en`=1, each `wclk` edge shifts in `shift_din`. Bit k of the 36-bit sequence is almost-empty bit k for k<18, and almost-full bit k-18 otherwise. Both offsets update on the edge of the 36th bit, and the count then restarts.
- R9: In parallel mode, `shift_en` has no effect on either offset.
- R10: With `load`=0, `mem_wr` equals `wr_en` and `mem_rd` equals `rd_en` in the same cycle, with no clock. With `load`=1, both are 0.
- R11: With no strobe asserted, both offsets hold, `ofs_dout_vld` is 0 and neither memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock: slot writes, serial shifts, offset registers |
| rclk | input | 1 | Read clock: slot read-back |
| mrst | input | 1 | Master reset, active high, synchronous to both clocks |
| mode_sel | input | 1 | Loading method sampled during master reset (1 = serial) |
| load | input | 1 | Routes write/read enables to the offset registers |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| shift_en | input | 1 | Serial shift strobe |
| shift_din | input | 1 | Serial data bit |
| din | input | SLOT_W | Parallel slot data |
| mem_wr | output | 1 | Memory write request passed through |
| mem_rd | output | 1 | Memory read request passed through |
| ofs_dout | output | SLOT_W | Slot value read back |
| ofs_dout_vld | output | 1 | High for the cycle after a slot read |
| empty_ofs | output | OFS_W | Committed almost-empty offset |
| full_ofs | output | OFS_W | Committed almost-full offset |
| serial_mode | output | 1 | Latched loading method |

## Verification
The assertions assume that `mrst` stays high across at least one edge of each clock, and that `mode_sel` counts only during that window. They also assume that the read-back clock samples offset values that are stable in the write domain. The bench therefore runs both clocks from one source and holds reset for two edges. It mixes seeded random strobe patterns with directed slot walks, a full 36-bit serial load and mode-gated attempts that must be ignored. Any combination of strobes is legal at the ports, so the stimulus draws all of them. It is biased only so that serial loads complete several times within the run.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

  // Write-clock operation chosen by the strobe decode
  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_MEM   = 2'd1,
    W_OFS   = 2'd2,
    W_SHIFT = 2'd3
  } w_op_e;

  // Read-clock operation chosen by the strobe decode
  typedef enum logic [1:0] {
    R_IDLE = 2'd0,
    R_MEM  = 2'd1,
    R_OFS  = 2'd2
  } r_op_e;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  // Position of a slot inside its offset (0 = low part)
  function automatic int unsigned slot_index(input int unsigned ptr, input int unsigned spo);
    return (ptr >= spo) ? ptr - spo : ptr;
  endfunction

  // Slot belongs to the almost-full offset
  function automatic logic slot_is_full(input int unsigned ptr, input int unsigned spo);
    return ptr >= spo;
  endfunction

  // Next slot in the cyclic order
  function automatic int unsigned slot_next(input int unsigned ptr, input int unsigned nslot);
    return (ptr == nslot - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/ofl_op_decode.sv
module ofl_op_decode
  import ofl_pkg::*;
(
  input  logic  wclk,
  input  logic  mrst,
  input  logic  mode_sel,
  input  logic  load,
  input  logic  wr_en,
  input  logic  rd_en,
  input  logic  shift_en,
  output logic  serial_mode,
  output w_op_e w_op,
  output r_op_e r_op,
  output logic  mem_wr,
  output logic  mem_rd
);

  // Loading method follows the mode input only while master reset is held
  always_ff @(posedge wclk) begin
    if (mrst) serial_mode <= mode_sel;
  end

  always_comb begin
    if (load)
      w_op = (wr_en && !serial_mode) ? W_OFS : W_IDLE;
    else if (wr_en)
      w_op = W_MEM;
    else if (shift_en && !rd_en && serial_mode)
      w_op = W_SHIFT;
    else
      w_op = W_IDLE;
  end

  always_comb begin
    if (rd_en) r_op = load ? R_OFS : R_MEM;
    else       r_op = R_IDLE;
  end

  assign mem_wr = (w_op == W_MEM);
  assign mem_rd = (r_op == R_MEM);

  AST_MODE_FROZEN: assert property (@(posedge wclk) disable iff (mrst)
    !mrst |=> $stable(serial_mode)); // R1

endmodule

// File: rtl/ofl_par_writer.sv
module ofl_par_writer
  import ofl_pkg::*;
#(
  parameter int unsigned OFS_W  = 18,
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_mode,
  input  logic              wr_evt,
  input  logic [SLOT_W-1:0] din,
  output logic              commit_empty,
  output logic              commit_full,
  output logic [OFS_W-1:0]  commit_val
);

  localparam int unsigned SPO   = ceil_div(OFS_W, SLOT_W);
  localparam int unsigned NSLOT = 2 * SPO;
  localparam int unsigned PTR_W = $clog2(NSLOT);

  logic [PTR_W-1:0] wptr;
  logic [OFS_W-1:0] stage;
  logic [31:0]      wptr_ext;
  int unsigned      idx;
  logic             last_part;

  // Replace the bits of one slot inside a partially built offset
  function automatic logic [OFS_W-1:0] put_slot(input logic [OFS_W-1:0] cur,
                                               input int unsigned       sidx,
                                               input logic [SLOT_W-1:0] b);
    logic [OFS_W-1:0] r;
    r = cur;
    for (int unsigned k = 0; k < SLOT_W; k++) begin
      if (sidx * SLOT_W + k < OFS_W) r[sidx*SLOT_W+k] = b[k];
    end
    return r;
  endfunction

  assign wptr_ext  = 32'(wptr);
  assign idx       = slot_index(wptr_ext, SPO);
  assign last_part = (idx == SPO - 1);
  assign commit_val   = put_slot(stage, idx, din);
  assign commit_empty = wr_evt && last_part && !slot_is_full(wptr_ext, SPO);
  assign commit_full  = wr_evt && last_part &&  slot_is_full(wptr_ext, SPO);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      stage <= '0;
    end else if (wr_evt) begin
      stage <= commit_val;
      wptr  <= PTR_W'(slot_next(wptr_ext, NSLOT));
    end
  end

  AST_WPTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && wptr == PTR_W'(NSLOT - 1)) |=> (wptr == '0)); // R3

  AST_PAR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    serial_mode |=> $stable(wptr) && $stable(stage)); // R7

endmodule

// File: rtl/ofl_ser_shifter.sv
module ofl_ser_shifter #(
  parameter int unsigned OFS_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serial_mode,
  input  logic             shift_evt,
  input  logic             shift_din,
  output logic             done,
  output logic [OFS_W-1:0] ser_empty,
  output logic [OFS_W-1:0] ser_full
);

  localparam int unsigned CHAIN_W = 2 * OFS_W;
  localparam int unsigned CNT_W   = $clog2(CHAIN_W);

  logic [CHAIN_W-1:0] chain;
  logic [CHAIN_W-1:0] chain_nxt;
  logic [CNT_W-1:0]   cnt;

  // New bits enter at the top, so the first bit ends at position 0
  assign chain_nxt = {shift_din, chain[CHAIN_W-1:1]};
  assign done      = shift_evt && (cnt == CNT_W'(CHAIN_W - 1));
  assign ser_empty = chain_nxt[OFS_W-1:0];
  assign ser_full  = chain_nxt[CHAIN_W-1:OFS_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      cnt   <= '0;
    end else if (shift_evt) begin
      chain <= chain_nxt;
      cnt   <= done ? '0 : cnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CHAIN_W - 1)); // R8

  AST_SER_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !serial_mode |=> $stable(chain) && $stable(cnt)); // R9

endmodule

// File: rtl/ofl_par_reader.sv
module ofl_par_reader
  import ofl_pkg::*;
#(
  parameter int unsigned OFS_W  = 18,
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_evt,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [SLOT_W-1:0] dout,
  output logic              dout_vld
);

  localparam int unsigned SPO   = ceil_div(OFS_W, SLOT_W);
  localparam int unsigned NSLOT = 2 * SPO;
  localparam int unsigned PTR_W = $clog2(NSLOT);

  logic [PTR_W-1:0]  rptr;
  logic [31:0]       rptr_ext;
  logic [OFS_W-1:0]  sel_ofs;
  logic [SLOT_W-1:0] slot_val;

  // Extract one slot, zero-filling bits past the offset width
  function automatic logic [SLOT_W-1:0] get_slot(input logic [OFS_W-1:0] v,
                                                input int unsigned      sidx);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int unsigned k = 0; k < SLOT_W; k++) begin
      if (sidx * SLOT_W + k < OFS_W) r[k] = v[sidx*SLOT_W+k];
    end
    return r;
  endfunction

  assign rptr_ext = 32'(rptr);
  assign sel_ofs  = slot_is_full(rptr_ext, SPO) ? full_ofs : empty_ofs;
  assign slot_val = get_slot(sel_ofs, slot_index(rptr_ext, SPO));

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr     <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= rd_evt;
      if (rd_evt) begin
        dout <= slot_val;
        rptr <= PTR_W'(slot_next(rptr_ext, NSLOT));
      end
    end
  end

  AST_RPTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && rptr == PTR_W'(NSLOT - 1)) |=> (rptr == '0)); // R5

endmodule

// File: rtl/ofl_offset_loader.sv
module ofl_offset_loader
  import ofl_pkg::*;
#(
  parameter int unsigned OFS_W     = 18,
  parameter int unsigned SLOT_W    = 8,
  parameter int unsigned EMPTY_DEF = 7,
  parameter int unsigned FULL_DEF  = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              mode_sel,
  input  logic              load,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              shift_en,
  input  logic              shift_din,
  input  logic [SLOT_W-1:0] din,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [SLOT_W-1:0] ofs_dout,
  output logic              ofs_dout_vld,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              serial_mode
);

  w_op_e            w_op;
  r_op_e            r_op;
  logic             ofs_wr_evt;
  logic             ofs_rd_evt;
  logic             shift_evt;
  logic             commit_empty;
  logic             commit_full;
  logic [OFS_W-1:0] commit_val;
  logic             ser_done;
  logic [OFS_W-1:0] ser_empty;
  logic [OFS_W-1:0] ser_full;

  ofl_op_decode u_decode (
    .wclk        (wclk),
    .mrst        (mrst),
    .mode_sel    (mode_sel),
    .load        (load),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .shift_en    (shift_en),
    .serial_mode (serial_mode),
    .w_op        (w_op),
    .r_op        (r_op),
    .mem_wr      (mem_wr),
    .mem_rd      (mem_rd)
  );

  assign ofs_wr_evt = (w_op == W_OFS);
  assign shift_evt  = (w_op == W_SHIFT);
  assign ofs_rd_evt = (r_op == R_OFS);

  ofl_par_writer #(.OFS_W(OFS_W), .SLOT_W(SLOT_W)) u_writer (
    .clk          (wclk),
    .rst          (mrst),
    .serial_mode  (serial_mode),
    .wr_evt       (ofs_wr_evt),
    .din          (din),
    .commit_empty (commit_empty),
    .commit_full  (commit_full),
    .commit_val   (commit_val)
  );

  ofl_ser_shifter #(.OFS_W(OFS_W)) u_shifter (
    .clk         (wclk),
    .rst         (mrst),
    .serial_mode (serial_mode),
    .shift_evt   (shift_evt),
    .shift_din   (shift_din),
    .done        (ser_done),
    .ser_empty   (ser_empty),
    .ser_full    (ser_full)
  );

  // Committed offsets seen by the flag comparators
  always_ff @(posedge wclk) begin
    if (mrst) begin
      empty_ofs <= OFS_W'(EMPTY_DEF);
      full_ofs  <= OFS_W'(FULL_DEF);
    end else if (ser_done) begin
      empty_ofs <= ser_empty;
      full_ofs  <= ser_full;
    end else begin
      if (commit_empty) empty_ofs <= commit_val;
      if (commit_full)  full_ofs  <= commit_val;
    end
  end

  ofl_par_reader #(.OFS_W(OFS_W), .SLOT_W(SLOT_W)) u_reader (
    .clk       (rclk),
    .rst       (mrst),
    .rd_evt    (ofs_rd_evt),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .dout      (ofs_dout),
    .dout_vld  (ofs_dout_vld)
  );

  AST_EMPTY_HOLD: assert property (@(posedge wclk) disable iff (mrst)
    !(commit_empty || ser_done) |=> $stable(empty_ofs)); // R4

  AST_FULL_HOLD: assert property (@(posedge wclk) disable iff (mrst)
    !(commit_full || ser_done) |=> $stable(full_ofs)); // R4

  AST_NO_DUAL_COMMIT: assert property (@(posedge wclk) disable iff (mrst)
    !(ser_done && (commit_empty || commit_full))); // R8

endmodule

// File: tb/ofl_offset_loader_tb.sv
module ofl_offset_loader_tb;

  localparam int OW = 18;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic mrst = 1'b1;
  logic mode_sel = 1'b0;
  logic load = 1'b0, wr_en = 1'b0, rd_en = 1'b0, shift_en = 1'b0, shift_din = 1'b0;
  logic [SW-1:0] din = '0;
  logic mem_wr, mem_rd, ofs_dout_vld, serial_mode;
  logic [SW-1:0] ofs_dout;
  logic [OW-1:0] empty_ofs, full_ofs;

  int n_chk = 0;
  int n_err = 0;

  // model state
  bit [OW-1:0] m_empty, m_full, m_stage;
  bit [35:0]   m_chain;
  int          m_wptr, m_rptr, m_bits;
  bit          m_serial;
  bit          e_vld;
  bit [SW-1:0] e_dout;

  always #5 clk = ~clk;

  ofl_offset_loader #(.OFS_W(OW), .SLOT_W(SW), .EMPTY_DEF(7), .FULL_DEF(7)) u_dut (
    .wclk(clk), .rclk(clk), .mrst(mrst), .mode_sel(mode_sel), .load(load),
    .wr_en(wr_en), .rd_en(rd_en), .shift_en(shift_en), .shift_din(shift_din),
    .din(din), .mem_wr(mem_wr), .mem_rd(mem_rd), .ofs_dout(ofs_dout),
    .ofs_dout_vld(ofs_dout_vld), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .serial_mode(serial_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Slot value by shifting, the bench's own formulation
  function automatic bit [SW-1:0] slot_of(input int ptr);
    bit [OW-1:0] src;
    src = (ptr < 3) ? m_empty : m_full;
    return SW'((src >> (8 * (ptr % 3))) & 18'hff);
  endfunction

  task automatic do_reset(input bit ser);
    @(negedge clk);
    mrst = 1'b1; mode_sel = ser;
    load = 0; wr_en = 0; rd_en = 0; shift_en = 0;
    @(negedge clk); @(negedge clk);
    mrst = 1'b0;
    m_empty = 18'd7; m_full = 18'd7; m_stage = '0; m_chain = '0;
    m_wptr = 0; m_rptr = 0; m_bits = 0; m_serial = ser;
    #1;
    chk("R2 empty_ofs reset", 32'(empty_ofs), 32'd7);
    chk("R2 full_ofs reset", 32'(full_ofs), 32'd7);
    chk("R2 ofs_dout_vld reset", 32'(ofs_dout_vld), 32'd0);
    chk("R1 serial_mode latched", 32'(serial_mode), 32'(ser));
  endtask

  task automatic step(input bit ld, input bit wr, input bit rd, input bit sh,
                      input bit sdi, input bit [SW-1:0] d);
    int sh8;
    @(negedge clk);
    load = ld; wr_en = wr; rd_en = rd; shift_en = sh; shift_din = sdi; din = d;
    #1;
    chk("R10 mem_wr", 32'(mem_wr), 32'(!ld && wr));
    chk("R10 mem_rd", 32'(mem_rd), 32'(!ld && rd));
    // read uses values before this edge
    e_vld = ld && rd;
    if (e_vld) begin
      e_dout = slot_of(m_rptr);
      m_rptr = (m_rptr + 1) % 6;
    end
    if (ld && wr && !m_serial) begin
      sh8 = 8 * (m_wptr % 3);
      m_stage = (m_stage & ~(18'hff << sh8)) | ((18'(d) << sh8) & 18'h3ffff);
      if (m_wptr == 2) m_empty = m_stage;
      if (m_wptr == 5) m_full = m_stage;
      m_wptr = (m_wptr + 1) % 6;
    end else if (!ld && !wr && !rd && sh && m_serial) begin
      m_chain = {sdi, m_chain[35:1]};
      m_bits++;
      if (m_bits == 36) begin
        m_bits = 0;
        m_empty = m_chain[17:0];
        m_full = m_chain[35:18];
      end
    end
    @(posedge clk); #2;
    chk("R4 empty_ofs", 32'(empty_ofs), 32'(m_empty));
    chk("R4 full_ofs", 32'(full_ofs), 32'(m_full));
    chk("R5 ofs_dout_vld", 32'(ofs_dout_vld), 32'(e_vld));
    if (e_vld) chk("R5 ofs_dout", 32'(ofs_dout), 32'(e_dout));
  endtask

  initial begin
    #(100000 * 10);
    n_err++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit [OW-1:0] ke, kf, se, sf;
    void'($urandom(32'd20240611));

    // parallel mode
    do_reset(1'b0);
    // R3: write empty 0x2_A5_3C, check staging holds until slot 2
    step(1, 1, 0, 0, 0, 8'h3C);
    chk("R4 empty staged after slot0", 32'(empty_ofs), 32'd7);
    step(1, 1, 0, 0, 0, 8'hA5);
    chk("R4 empty staged after slot1", 32'(empty_ofs), 32'd7);
    step(1, 1, 0, 0, 0, 8'hFE); // only bits 1:0 kept -> 2
    chk("R3 empty after slot2", 32'(empty_ofs), 32'h2A53C);
    chk("R4 full unchanged after empty", 32'(full_ofs), 32'd7);
    step(1, 1, 0, 0, 0, 8'h11);
    step(1, 1, 0, 0, 0, 8'h22);
    step(1, 1, 0, 0, 0, 8'h01);
    chk("R3 full after slot5", 32'(full_ofs), 32'h12211);
    // R3 wrap: next write goes to slot 0 of empty
    step(1, 1, 0, 0, 0, 8'h99);
    step(1, 1, 0, 0, 0, 8'h88);
    step(1, 1, 0, 0, 0, 8'h03);
    chk("R3 wrap to empty slot", 32'(empty_ofs), 32'h38899);
    // R5 read back seven slots (wraps)
    step(1, 0, 1, 0, 0, 8'h00);
    chk("R5 read slot0", 32'(ofs_dout), 32'h99);
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0, 8'h00);
    chk("R5 read slot5", 32'(ofs_dout), 32'h01);
    step(1, 0, 1, 0, 0, 8'h00);
    chk("R5 read wraps to slot0", 32'(ofs_dout), 32'h99);
    // R9 shifts ignored in parallel mode
    ke = empty_ofs; kf = full_ofs;
    for (int i = 0; i < 40; i++) step(0, 0, 0, 1, i[0], 8'h00);
    chk("R9 empty unchanged by shifts", 32'(empty_ofs), 32'(ke));
    chk("R9 full unchanged by shifts", 32'(full_ofs), 32'(kf));
    // R11 idle
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 8'hFF);
    chk("R11 empty holds idle", 32'(empty_ofs), 32'(ke));
    chk("R11 vld low idle", 32'(ofs_dout_vld), 32'd0);
    // random parallel traffic
    for (int i = 0; i < 2000; i++)
      step(($urandom % 3) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 2, SW'($urandom));

    // serial mode
    do_reset(1'b1);
    mode_sel = 1'b0;
    step(0, 0, 0, 0, 0, 8'h00);
    chk("R1 mode frozen after reset", 32'(serial_mode), 32'd1);
    se = 18'h2A5C3; sf = 18'h1F00F;
    for (int i = 0; i < 36; i++) begin
      step(0, 0, 0, 1, (i < 18) ? se[i] : sf[i-18], 8'h00);
      if (i == 34) chk("R8 no update before last bit", 32'(empty_ofs), 32'd7);
    end
    chk("R8 serial empty", 32'(empty_ofs), 32'(se));
    chk("R8 serial full", 32'(full_ofs), 32'(sf));
    // R7 parallel writes ignored
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, 8'h55);
    chk("R7 empty unchanged", 32'(empty_ofs), 32'(se));
    chk("R7 full unchanged", 32'(full_ofs), 32'(sf));
    // R6 read-back in serial mode
    step(1, 0, 1, 0, 0, 8'h00);
    chk("R6 serial read slot0", 32'(ofs_dout), 32'hC3);
    step(1, 0, 1, 0, 0, 8'h00);
    step(1, 0, 1, 0, 0, 8'h00);
    chk("R6 serial read slot2", 32'(ofs_dout), 32'h02);
    step(1, 0, 1, 0, 0, 8'h00);
    chk("R6 serial read slot3", 32'(ofs_dout), 32'h0F);
    // random serial traffic
    for (int i = 0; i < 2000; i++)
      step(($urandom % 8) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 4) != 0, $urandom % 2, SW'($urandom));

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule